// File: doc/BRIEF.md
# Progress Semaphore Release Unit

This unit executes release commands for an engine. A release names an address in shared memory and a 32-bit progress value that only increases. The unit holds the command until the engine reports that all earlier work is finished. Only then does it write the value to memory. A host that waits for operation N treats the wait as over once the stored word is at least N. The device only writes this location and the host only reads it, so no atomic operation is needed.

A free-running 64-bit cycle counter supplies timestamps. When the command asks for one, the counter is sampled at the same edge at which the unit sees the engine idle. The sample is written as two more words behind the value word, so the three words form one event record. When asked, the unit also pulses an interrupt once every write has been acknowledged. This lets a host thread sleep instead of polling the location.

Top module: `progress_release`

## Requirements
- R1: Reset leaves `cmd_ready` high and `wr_valid` and `irq` low.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the cycle after acceptance until the release is complete.
- R3: No write request is raised before `engine_idle` has been sampled high on a clock edge after acceptance.
- R4: The first write goes to `cmd_addr` and carries `cmd_value`.
- R5: When `cmd_flags` bit 0 is 1, two more writes follow in a fixed order: the low 32 bits of the timestamp at `cmd_addr`+4, then the high 32 bits at `cmd_addr`+8. When bit 0 is 0, only one write is made.
- R6: The timestamp equals the number of rising clock edges seen since reset was released, sampled at the edge where the waiting unit first sees `engine_idle` high.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R8: When `cmd_flags` bit 1 is 1, `irq` is high for exactly one cycle: the cycle after the edge that carries the last `wr_resp` of the release. When bit 1 is 0, `irq` stays low.
- R9: `cmd_ready` returns high in the cycle after the edge that carries the last `wr_resp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| engine_idle | input | 1 | High when all earlier engine work has finished |
| cmd_valid | input | 1 | Release command present |
| cmd_ready | output | 1 | Unit can take a command |
| cmd_addr | input | 32 | Byte address of the sync record |
| cmd_value | input | 32 | Progress value to publish |
| cmd_flags | input | 2 | Bit 0: add timestamp; bit 1: raise interrupt |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| wr_resp | input | 1 | One-cycle acknowledge, one per accepted write |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Two pairs of events can fall on the same clock edge. In the first pair, a write is accepted while the response to an earlier word of the same record arrives. This is provoked with a one-cycle response latency and `wr_ready` held high, and it is judged by the count and order of the recorded writes. In the second pair, the next command is accepted in the very cycle the interrupt of the previous release is pulsing. The bench issues the second command at the first cycle `cmd_ready` is seen high again, then checks that the interrupt is counted exactly once and that the second value is written.

// File: rtl/progress_release.sv
module progress_release #(
  parameter int ADDR_W = 32,
  parameter int VAL_W  = 32,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              engine_idle,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [VAL_W-1:0]  cmd_value,
  input  logic [1:0]        cmd_flags,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [VAL_W-1:0]  wr_data,
  input  logic              wr_resp,
  output logic              irq
);
  localparam int TS_W = 2 * VAL_W;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND, S_DRAIN} state_t;

  state_t            st;
  logic [ADDR_W-1:0] base;
  logic [VAL_W-1:0]  val;
  logic [1:0]        flg;
  logic [TS_W-1:0]   ts, ts_cap;
  logic [1:0]        widx, rcnt;
  logic [1:0]        nwords;

  assign nwords    = flg[0] ? 2'd3 : 2'd1;
  assign cmd_ready = (st == S_IDLE);
  assign wr_valid  = (st == S_SEND);
  assign wr_addr   = base + ADDR_W'(widx) * ADDR_W'(STRIDE);
  assign wr_data   = (widx == 2'd0) ? val :
                     (widx == 2'd1) ? ts_cap[VAL_W-1:0] : ts_cap[TS_W-1:VAL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base   <= '0;
      val    <= '0;
      flg    <= '0;
      ts_cap <= '0;
      widx   <= '0;
      rcnt   <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (st != S_IDLE && wr_resp) rcnt <= rcnt + 1'b1;
      case (st)
        S_IDLE: if (cmd_valid) begin
          base <= cmd_addr;
          val  <= cmd_value;
          flg  <= cmd_flags;
          widx <= '0;
          rcnt <= '0;
          st   <= S_WAIT;
        end
        S_WAIT: if (engine_idle) begin
          ts_cap <= ts;
          st     <= S_SEND;
        end
        S_SEND: if (wr_ready) begin
          if (widx == nwords - 2'd1) st <= S_DRAIN;
          else                       widx <= widx + 1'b1;
        end
        S_DRAIN: if (wr_resp && rcnt == nwords - 2'd1) begin
          irq <= flg[1];
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
  // R3
  a_r3_no_write_when_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !wr_valid);
  // R7
  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R8
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r8_irq_follows_resp: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_resp));
  // R9
  a_r9_ready_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cmd_ready);
endmodule

// File: tb/progress_release_test.sv
module progress_release_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        engine_idle = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_value = '0;
  logic [1:0]  cmd_flags = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic        wr_resp;
  logic        irq;

  always #5 clk = ~clk;

  progress_release uut (
    .clk(clk), .rst_n(rst_n), .engine_idle(engine_idle),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_value(cmd_value), .cmd_flags(cmd_flags), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_resp(wr_resp), .irq(irq));

  integer errors = 0, checks = 0;
  int lat = 1;
  bit rmode = 1'b0;

  longint unsigned c;
  logic [3:0] pipe;
  logic [31:0] wa [0:255];
  logic [31:0] wd [0:255];
  int wn = 0, irq_n = 0, early = 0, stab_err = 0;
  longint unsigned irq_c, last_resp, rdy_cyc, exp_ts;
  bit cap_pend = 0, busy_m = 0, prev_hold = 0;
  logic [31:0] prev_a, prev_d;

  assign wr_resp = pipe[lat-1];

  always @(negedge clk) wr_ready = rmode ? c[0] : 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      c <= 0;
      pipe <= '0;
    end else begin
      c <= c + 1;
      pipe <= {pipe[2:0], wr_valid && wr_ready};
      if (wr_valid && wr_ready && wn < 256) begin
        wa[wn] <= wr_addr;
        wd[wn] <= wr_data;
        wn <= wn + 1;
      end
      if (wr_valid && cap_pend) early <= early + 1;
      if (prev_hold && (!wr_valid || wr_addr != prev_a || wr_data != prev_d))
        stab_err <= stab_err + 1;
      prev_hold <= wr_valid && !wr_ready;
      prev_a <= wr_addr;
      prev_d <= wr_data;
      if (wr_resp) last_resp <= c;
      if (irq) begin
        irq_n <= irq_n + 1;
        irq_c <= c;
      end
      if (cap_pend && engine_idle) begin
        exp_ts <= c;
        cap_pend <= 1'b0;
      end
      if (busy_m && cmd_ready) begin
        rdy_cyc <= c;
        busy_m <= 1'b0;
      end
      if (cmd_valid && cmd_ready) begin
        busy_m <= 1'b1;
        cap_pend <= 1'b1;
      end
    end
  end

  always @(posedge clk) if (c == 150000) begin
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual cycles %0d, expected fewer)", c);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 200 && !cmd_ready; k++) @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] v, input logic [1:0] f);
    cmd_addr = a;
    cmd_value = v;
    cmd_flags = f;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2 busy after accept", cmd_ready, 0);
  endtask

  task automatic run_case(input logic [1:0] f, input int l, input bit r, input int d,
                          input int idx);
    int w0, i0, n;
    logic [31:0] a, v;
    lat = l;
    rmode = r;
    engine_idle = (d == 0);
    wait_ready();
    w0 = wn;
    i0 = irq_n;
    a = 32'h1000 + 32'(idx) * 16;
    v = 32'd100 + 32'(idx);
    n = f[0] ? 3 : 1;
    issue(a, v, f);
    if (d > 0) begin
      repeat (d) @(negedge clk);
      chk(wn == w0 && !wr_valid, "R3 no write while engine busy", wn - w0, 0);
      engine_idle = 1'b1;
    end
    wait_ready();
    @(negedge clk);
    @(negedge clk);
    chk(wn - w0 == n, "R5 write count", wn - w0, n);
    chk(wa[w0] == a && wd[w0] == v, "R4 value word", {wa[w0], wd[w0]}, {a, v});
    if (f[0]) begin
      chk(wa[w0+1] == a + 4 && wd[w0+1] == exp_ts[31:0], "R5 R6 timestamp low word",
          {wa[w0+1], wd[w0+1]}, {a + 32'd4, exp_ts[31:0]});
      chk(wa[w0+2] == a + 8 && wd[w0+2] == exp_ts[63:32], "R5 R6 timestamp high word",
          {wa[w0+2], wd[w0+2]}, {a + 32'd8, exp_ts[63:32]});
    end
    chk(irq_n - i0 == int'(f[1]), "R8 interrupt count", irq_n - i0, f[1]);
    if (f[1]) chk(irq_c == last_resp + 1, "R8 interrupt timing", irq_c, last_resp + 1);
    chk(rdy_cyc == last_resp + 1, "R9 ready return", rdy_cyc, last_resp + 1);
    chk(early == 0, "R3 early write", early, 0);
    chk(stab_err == 0, "R7 request stability", stab_err, 0);
  endtask

  initial begin
    int idx;
    int w0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(cmd_ready && !wr_valid && !irq, "R1 reset state", {cmd_ready, wr_valid, irq}, 3'b100);
    idx = 0;
    for (int f = 0; f < 4; f++)
      for (int l = 1; l <= 3; l++)
        for (int r = 0; r < 2; r++)
          for (int d = 0; d <= 3; d += 3) begin
            run_case(2'(f), l, r[0], d, idx);
            idx++;
          end
    lat = 1;
    rmode = 1'b0;
    engine_idle = 1'b1;
    wait_ready();
    w0 = wn;
    i0 = irq_n;
    issue(32'h8000, 32'd500, 2'b11);
    wait_ready();
    issue(32'h9000, 32'd501, 2'b00);
    wait_ready();
    repeat (3) @(negedge clk);
    chk(irq_n - i0 == 1, "R8 interrupt during next accept", irq_n - i0, 1);
    chk(wn - w0 == 4, "R5 back-to-back write count", wn - w0, 4);
    chk(wa[w0+3] == 32'h9000 && wd[w0+3] == 32'd501, "R4 second command value",
        {wa[w0+3], wd[w0+3]}, {32'h9000, 32'd501});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule